// File: doc/BRIEF.md
# Exception Entry Sequencer

This block carries a processor through the hardware part of entering an exception handler. When an exception request arrives while it is idle, it records the current program counter, code page, status word and stack pointer, together with the vector number and the address-mode select. It then saves the context on a stack that grows downward, using a word-wide memory write port. Next it clears the trace bit of the status word and fetches the handler address from the vector table through a memory read port. It finishes by loading that address into the program counter. The updated program counter, code page, status word and stack pointer stay on its outputs until the next entry.

Every memory access is a request that is held until the memory returns ready. A busy output covers the whole entry, and the block ignores new requests during that time. In small-address mode only the program counter and the status word are saved, and each vector entry is one word. In large-address mode the code page is saved as well, and each vector entry is two words that give the target page and the target offset.

The state machine has seven states. IDLE waits for a request. PUSH_PC, PUSH_PG and PUSH_SR each write one word. CLR_T is a single cycle that clears the trace bit. VEC_PG and VEC_OFS each read one word. Each state leaves only on its own completion condition:
- IDLE goes to PUSH_PC on accept.
- PUSH_PC goes to PUSH_PG in large mode and to PUSH_SR in small mode, on a write ready.
- PUSH_PG goes to PUSH_SR on a write ready.
- PUSH_SR goes to CLR_T on a write ready.
- CLR_T goes to VEC_PG in large mode and to VEC_OFS in small mode, with no condition.
- VEC_PG goes to VEC_OFS on a read ready.
- VEC_OFS goes to IDLE on a read ready.

Top module: `exc_entry_seq`

## Requirements
- R1: While reset is applied and directly after it, busy, wr_req and rd_req are 0, and pc_out, page_out, sr_out and sp_out are all zero.
- R2: When exc_req is high in an idle cycle, busy is 1 in the next cycle. In that cycle pc_out, page_out, sr_out and sp_out equal the pc_in, page_in, sr_in and sp_in values sampled at acceptance.
- R3: The first write goes to address sp-2 and carries the saved program counter. sp_out drops by exactly 2 in the cycle after each write that completes (wr_req and wr_rdy both high).
- R4: In large-address mode (big_mode=1) the second write carries the saved code page zero-extended to 16 bits, that is {8'h00, page}.
- R5: The status word is the last word written. In small-address mode (big_mode=0) only two words are written, the program counter and then the status word.
- R6: After the status write completes there is exactly one cycle with no memory request. After that cycle sr_out bit 15 (the trace bit) is 0 and every other bit is unchanged.
- R7: In small-address mode one read is made at address vector*2. The returned word becomes pc_out, and page_out keeps its captured value.
- R8: In large-address mode the block reads address vector*4 first; bits 7:0 of that word are the target page. It then reads vector*4+2 to get the offset. page_out and pc_out change together, after the second read.
- R9: A request (wr_req or rd_req) stays high with a stable address and stable data until its ready input is high. The two requests are never high together.
- R10: busy stays high from the cycle after acceptance until the cycle after the final read completes. When not busy, no memory request is made. exc_req is ignored while busy.
- R11: Changes to vector, big_mode, pc_in, page_in, sr_in and sp_in after acceptance have no effect on the entry in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_req | input | 1 | Exception request, sampled when idle |
| vector | input | 7 | Exception vector number |
| big_mode | input | 1 | 1 = large-address mode, 0 = small-address mode |
| pc_in | input | 16 | Current program counter |
| page_in | input | 8 | Current code page |
| sr_in | input | 16 | Current status word |
| sp_in | input | 16 | Current stack pointer |
| wr_req | output | 1 | Memory write request |
| wr_addr | output | 16 | Write address |
| wr_data | output | 16 | Write data |
| wr_rdy | input | 1 | Write ready |
| rd_req | output | 1 | Memory read request |
| rd_addr | output | 16 | Read address |
| rd_data | input | 16 | Read data, valid with rd_rdy |
| rd_rdy | input | 1 | Read ready |
| busy | output | 1 | High while an entry is in progress |
| pc_out | output | 16 | Updated program counter |
| page_out | output | 8 | Updated code page |
| sr_out | output | 16 | Updated status word |
| sp_out | output | 16 | Updated stack pointer |

## Verification
Acceptance shows up one cycle after the edge that sampled exc_req: busy and the captured context both appear then. Each completed write lowers sp_out one cycle after the edge where wr_rdy was seen. The trace bit clears one cycle after CLR_T. pc_out and page_out change one cycle after the edge where the final rd_rdy was seen. The bench drives inputs and compares outputs at the falling edge. It keeps a queue of the memory operations still expected in the current entry, and it retires the head of that queue only when the following rising edge will see the matching ready. Every output is therefore compared in exactly the cycle it is due, including under random stalls and while requests, modes and vectors are changed during an entry.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    // States of the entry sequence, in the order they are normally visited.
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_PUSH_PC = 3'd1,
        ST_PUSH_PG = 3'd2,
        ST_PUSH_SR = 3'd3,
        ST_CLR_T   = 3'd4,
        ST_VEC_PG  = 3'd5,
        ST_VEC_OFS = 3'd6
    } ent_state_t;

    function automatic logic is_push(input ent_state_t s);
        return (s == ST_PUSH_PC) || (s == ST_PUSH_PG) || (s == ST_PUSH_SR);
    endfunction

    function automatic logic is_fetch(input ent_state_t s);
        return (s == ST_VEC_PG) || (s == ST_VEC_OFS);
    endfunction

endpackage

// File: rtl/ees_fsm.sv
module ees_fsm
    import exc_entry_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       exc_req,
    input  logic       big_lat,
    input  logic       wr_rdy,
    input  logic       rd_rdy,
    output ent_state_t state_q,
    output logic       accept,
    output logic       wr_req,
    output logic       rd_req,
    output logic       wr_done,
    output logic       rd_done,
    output logic       busy
);

    ent_state_t state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (exc_req) state_d = ST_PUSH_PC;
            ST_PUSH_PC: if (wr_rdy)  state_d = big_lat ? ST_PUSH_PG : ST_PUSH_SR;
            ST_PUSH_PG: if (wr_rdy)  state_d = ST_PUSH_SR;
            ST_PUSH_SR: if (wr_rdy)  state_d = ST_CLR_T;
            ST_CLR_T:                state_d = big_lat ? ST_VEC_PG : ST_VEC_OFS;
            ST_VEC_PG:  if (rd_rdy)  state_d = ST_VEC_OFS;
            ST_VEC_OFS: if (rd_rdy)  state_d = ST_IDLE;
            default:                 state_d = ST_IDLE;
        endcase
    end

    // Outputs decoded from the current state
    always_comb begin
        busy    = (state_q != ST_IDLE);
        accept  = (state_q == ST_IDLE) && exc_req;
        wr_req  = is_push(state_q);
        rd_req  = is_fetch(state_q);
        wr_done = wr_req && wr_rdy;
        rd_done = rd_req && rd_rdy;
    end

    // R9: a request is never dropped before its ready
    p_wr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !wr_rdy) |=> wr_req);
    p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_rdy) |=> rd_req);
    p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_req && rd_req));

    // R10: no memory traffic while idle
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!wr_req && !rd_req));

endmodule

// File: rtl/ees_ctx.sv
module ees_ctx
    import exc_entry_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int PAGE_W = 8,
    parameter int VEC_W  = 7,
    parameter int T_BIT  = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ent_state_t        state_q,
    input  logic              accept,
    input  logic              wr_done,
    input  logic              rd_done,
    input  logic [WORD_W-1:0] pc_in,
    input  logic [PAGE_W-1:0] page_in,
    input  logic [WORD_W-1:0] sr_in,
    input  logic [WORD_W-1:0] sp_in,
    input  logic [VEC_W-1:0]  vec_in,
    input  logic              big_in,
    input  logic [WORD_W-1:0] rd_data,
    output logic [WORD_W-1:0] pc_q,
    output logic [PAGE_W-1:0] page_q,
    output logic [WORD_W-1:0] sr_q,
    output logic [WORD_W-1:0] sp_q,
    output logic [VEC_W-1:0]  vec_q,
    output logic              big_q
);

    localparam int STEP = WORD_W / 8;

    logic [PAGE_W-1:0] pg_tmp;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q   <= '0;
            page_q <= '0;
            sr_q   <= '0;
            sp_q   <= '0;
            vec_q  <= '0;
            big_q  <= 1'b0;
            pg_tmp <= '0;
        end else begin
            if (accept) begin
                pc_q   <= pc_in;
                page_q <= page_in;
                sr_q   <= sr_in;
                sp_q   <= sp_in;
                vec_q  <= vec_in;
                big_q  <= big_in;
            end
            if (wr_done) sp_q <= sp_q - WORD_W'(STEP);
            if (state_q == ST_CLR_T) sr_q[T_BIT] <= 1'b0;
            if (rd_done && (state_q == ST_VEC_PG)) pg_tmp <= rd_data[PAGE_W-1:0];
            if (rd_done && (state_q == ST_VEC_OFS)) begin
                pc_q <= rd_data;
                if (big_q) page_q <= pg_tmp;
            end
        end
    end

    // R7: small mode leaves the page untouched when the target loads
    p_page_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_done && (state_q == ST_VEC_OFS) && !big_q) |=> (page_q == $past(page_q)));

endmodule

// File: rtl/ees_addr.sv
module ees_addr
    import exc_entry_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int PAGE_W = 8,
    parameter int VEC_W  = 7
) (
    input  ent_state_t        state_q,
    input  logic [WORD_W-1:0] pc_q,
    input  logic [PAGE_W-1:0] page_q,
    input  logic [WORD_W-1:0] sr_q,
    input  logic [WORD_W-1:0] sp_q,
    input  logic [VEC_W-1:0]  vec_q,
    input  logic              big_q,
    output logic [WORD_W-1:0] wr_addr,
    output logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] rd_addr
);

    localparam int STEP     = WORD_W / 8;
    localparam int SMALL_SH = $clog2(STEP);
    localparam int LARGE_SH = SMALL_SH + 1;

    logic [WORD_W-1:0] vec_x;
    logic [WORD_W-1:0] small_ent;
    logic [WORD_W-1:0] large_ent;

    assign vec_x     = WORD_W'(vec_q);
    assign small_ent = vec_x << SMALL_SH;
    assign large_ent = vec_x << LARGE_SH;
    assign wr_addr   = sp_q - WORD_W'(STEP);

    always_comb begin
        unique case (state_q)
            ST_PUSH_PC: wr_data = pc_q;
            ST_PUSH_PG: wr_data = WORD_W'(page_q);
            ST_PUSH_SR: wr_data = sr_q;
            default:    wr_data = '0;
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_VEC_PG:  rd_addr = large_ent;
            ST_VEC_OFS: rd_addr = big_q ? (large_ent + WORD_W'(STEP)) : small_ent;
            default:    rd_addr = '0;
        endcase
    end

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_entry_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int PAGE_W = 8,
    parameter int VEC_W  = 7,
    parameter int T_BIT  = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exc_req,
    input  logic [VEC_W-1:0]  vector,
    input  logic              big_mode,
    input  logic [WORD_W-1:0] pc_in,
    input  logic [PAGE_W-1:0] page_in,
    input  logic [WORD_W-1:0] sr_in,
    input  logic [WORD_W-1:0] sp_in,
    output logic              wr_req,
    output logic [WORD_W-1:0] wr_addr,
    output logic [WORD_W-1:0] wr_data,
    input  logic              wr_rdy,
    output logic              rd_req,
    output logic [WORD_W-1:0] rd_addr,
    input  logic [WORD_W-1:0] rd_data,
    input  logic              rd_rdy,
    output logic              busy,
    output logic [WORD_W-1:0] pc_out,
    output logic [PAGE_W-1:0] page_out,
    output logic [WORD_W-1:0] sr_out,
    output logic [WORD_W-1:0] sp_out
);

    ent_state_t       state_q;
    logic             accept;
    logic             wr_done;
    logic             rd_done;
    logic [VEC_W-1:0] vec_q;
    logic             big_q;

    ees_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .exc_req (exc_req),
        .big_lat (big_q),
        .wr_rdy  (wr_rdy),
        .rd_rdy  (rd_rdy),
        .state_q (state_q),
        .accept  (accept),
        .wr_req  (wr_req),
        .rd_req  (rd_req),
        .wr_done (wr_done),
        .rd_done (rd_done),
        .busy    (busy)
    );

    ees_ctx #(
        .WORD_W (WORD_W),
        .PAGE_W (PAGE_W),
        .VEC_W  (VEC_W),
        .T_BIT  (T_BIT)
    ) u_ctx (
        .clk     (clk),
        .rst_n   (rst_n),
        .state_q (state_q),
        .accept  (accept),
        .wr_done (wr_done),
        .rd_done (rd_done),
        .pc_in   (pc_in),
        .page_in (page_in),
        .sr_in   (sr_in),
        .sp_in   (sp_in),
        .vec_in  (vector),
        .big_in  (big_mode),
        .rd_data (rd_data),
        .pc_q    (pc_out),
        .page_q  (page_out),
        .sr_q    (sr_out),
        .sp_q    (sp_out),
        .vec_q   (vec_q),
        .big_q   (big_q)
    );

    ees_addr #(
        .WORD_W (WORD_W),
        .PAGE_W (PAGE_W),
        .VEC_W  (VEC_W)
    ) u_addr (
        .state_q (state_q),
        .pc_q    (pc_out),
        .page_q  (page_out),
        .sr_q    (sr_out),
        .sp_q    (sp_out),
        .vec_q   (vec_q),
        .big_q   (big_q),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr)
    );

    // R2: busy only rises after a sampled request
    p_busy_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(exc_req));

    // R3: a completed push leaves the stack pointer at the written address
    p_sp_follows_push_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && wr_rdy) |=> (sp_out == $past(wr_addr)));

    // R6: the trace bit is already clear whenever the vector table is read
    p_t_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> !sr_out[T_BIT]);

    // R9: stalled write and read present stable address and data
    p_wr_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !wr_rdy) |=> ($stable(wr_addr) && $stable(wr_data)));
    p_rd_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_rdy) |=> $stable(rd_addr));

endmodule

// File: tb/exc_entry_seq_tb_top.sv
`timescale 1ns/1ps
module exc_entry_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exc_req = 1'b0;
    logic [6:0]  vector = '0;
    logic        big_mode = 1'b0;
    logic [15:0] pc_in = '0;
    logic [7:0]  page_in = '0;
    logic [15:0] sr_in = '0;
    logic [15:0] sp_in = '0;
    logic        wr_req;
    logic [15:0] wr_addr;
    logic [15:0] wr_data;
    logic        wr_rdy = 1'b0;
    logic        rd_req;
    logic [15:0] rd_addr;
    logic [15:0] rd_data;
    logic        rd_rdy = 1'b0;
    logic        busy;
    logic [15:0] pc_out;
    logic [7:0]  page_out;
    logic [15:0] sr_out;
    logic [15:0] sp_out;

    always #2.5 clk = ~clk;

    function automatic logic [15:0] tbl(input logic [15:0] a);
        return (a * 16'h2F1B) ^ 16'hC3A5;
    endfunction

    assign rd_data = tbl(rd_addr);

    exc_entry_seq dut_i (
        .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .vector(vector),
        .big_mode(big_mode), .pc_in(pc_in), .page_in(page_in), .sr_in(sr_in),
        .sp_in(sp_in), .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_rdy(wr_rdy), .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data),
        .rd_rdy(rd_rdy), .busy(busy), .pc_out(pc_out), .page_out(page_out),
        .sr_out(sr_out), .sp_out(sp_out)
    );

    int checks = 0;
    int errors = 0;

    // Model: queue of memory operations still owed by the current entry.
    // kind 0 = write, 1 = trace-clear cycle, 2 = page read, 3 = offset read
    typedef struct {
        int          kind;
        logic [15:0] addr;
        logic [15:0] data;
        string       tag;
    } op_t;
    op_t q[$];

    logic [15:0] m_pc = '0, m_sr = '0, m_sp = '0;
    logic [7:0]  m_page = '0, m_pgtmp = '0;
    logic        m_big = 1'b0;
    logic        just_acc = 1'b0;
    logic        cur_noisy = 1'b0;

    logic [15:0] s_pc, s_sr, s_sp;
    logic [7:0]  s_page;
    logic [6:0]  s_vec;
    logic        s_big;

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic compare();
        string tb_ = just_acc ? "R2" : "R10";
        chk(32'(busy), 32'(q.size() != 0), tb_);
        if (q.size() == 0) begin
            chk(32'(wr_req), 0, "R10");
            chk(32'(rd_req), 0, "R10");
        end else begin
            case (q[0].kind)
                0: begin
                    chk(32'(wr_req), 1, "R9");
                    chk(32'(rd_req), 0, "R9");
                    chk(32'(wr_addr), 32'(q[0].addr), q[0].tag);
                    chk(32'(wr_data), 32'(q[0].data), q[0].tag);
                end
                1: begin
                    chk(32'(wr_req), 0, "R6");
                    chk(32'(rd_req), 0, "R6");
                end
                default: begin
                    chk(32'(rd_req), 1, "R9");
                    chk(32'(wr_req), 0, "R9");
                    chk(32'(rd_addr), 32'(q[0].addr), cur_noisy ? "R11" : q[0].tag);
                end
            endcase
        end
        chk(32'(pc_out),   32'(m_pc),   just_acc ? "R2" : "R7");
        chk(32'(page_out), 32'(m_page), just_acc ? "R2" : "R8");
        chk(32'(sr_out),   32'(m_sr),   just_acc ? "R2" : "R6");
        chk(32'(sp_out),   32'(m_sp),   just_acc ? "R2" : "R3");
    endtask

    task automatic tick(input logic req, input logic wr_r, input logic rd_r);
        @(negedge clk);
        compare();
        exc_req  = req;
        vector   = s_vec;
        big_mode = s_big;
        pc_in    = s_pc;
        page_in  = s_page;
        sr_in    = s_sr;
        sp_in    = s_sp;
        wr_rdy   = wr_r;
        rd_rdy   = rd_r;
        just_acc = 1'b0;
        if (q.size() == 0) begin
            if (req) begin
                logic [15:0] ve = 16'(s_vec);
                m_pc = s_pc; m_page = s_page; m_sr = s_sr; m_sp = s_sp; m_big = s_big;
                just_acc = 1'b1;
                q.push_back('{0, s_sp - 16'd2, s_pc, "R3"});
                if (s_big) begin
                    q.push_back('{0, s_sp - 16'd4, {8'h00, s_page}, "R4"});
                    q.push_back('{0, s_sp - 16'd6, s_sr, "R5"});
                end else begin
                    q.push_back('{0, s_sp - 16'd4, s_sr, "R5"});
                end
                q.push_back('{1, 16'h0, 16'h0, "R6"});
                if (s_big) begin
                    q.push_back('{2, ve * 16'd4, 16'h0, "R8"});
                    q.push_back('{3, ve * 16'd4 + 16'd2, 16'h0, "R8"});
                end else begin
                    q.push_back('{3, ve * 16'd2, 16'h0, "R7"});
                end
            end
        end else begin
            case (q[0].kind)
                0: if (wr_r) begin m_sp = m_sp - 16'd2; void'(q.pop_front()); end
                1: begin m_sr[15] = 1'b0; void'(q.pop_front()); end
                2: if (rd_r) begin
                    logic [15:0] w = tbl(q[0].addr);
                    m_pgtmp = w[7:0];
                    void'(q.pop_front());
                end
                default: if (rd_r) begin
                    m_pc = tbl(q[0].addr);
                    if (m_big) m_page = m_pgtmp;
                    void'(q.pop_front());
                end
            endcase
        end
    endtask

    function automatic logic rdy(input logic stall);
        return stall ? (($urandom % 3) != 0) : 1'b1;
    endfunction

    task automatic run_entry(input logic big, input logic [6:0] vec, input logic [15:0] pc,
                             input logic [7:0] page, input logic [15:0] sr,
                             input logic [15:0] sp, input logic stall, input logic noisy);
        s_big = big; s_vec = vec; s_pc = pc; s_page = page; s_sr = sr; s_sp = sp;
        cur_noisy = 1'b0;
        tick(1'b1, rdy(stall), rdy(stall));
        cur_noisy = noisy;
        while (q.size() != 0) begin
            if (noisy) begin
                s_big = ~s_big; s_vec = 7'($urandom); s_pc = 16'($urandom);
                s_page = 8'($urandom); s_sr = 16'($urandom); s_sp = 16'($urandom);
            end
            tick(noisy, rdy(stall), rdy(stall));
        end
        cur_noisy = 1'b0;
    endtask

    initial begin
        s_big = 0; s_vec = 0; s_pc = 0; s_page = 0; s_sr = 0; s_sp = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(32'(busy), 0, "R1");
        chk(32'(wr_req), 0, "R1");
        chk(32'(rd_req), 0, "R1");
        chk(32'(pc_out), 0, "R1");
        chk(32'(page_out), 0, "R1");
        chk(32'(sr_out), 0, "R1");
        chk(32'(sp_out), 0, "R1");
        rst_n = 1'b1;
        // R10: idle with ready toggling, no requests
        for (int i = 0; i < 4; i++) tick(1'b0, 1'(i), 1'(i));
        // R7 / R5: small mode, no stalls, trace bit set
        run_entry(1'b0, 7'd5, 16'h1234, 8'h11, 16'hA0F3, 16'h0400, 1'b0, 1'b0);
        tick(1'b0, 1'b1, 1'b1);
        // R8 / R4: large mode, top vector
        run_entry(1'b1, 7'h7F, 16'hBEEF, 8'h3C, 16'hFFFF, 16'h8000, 1'b0, 1'b0);
        tick(1'b0, 1'b0, 1'b0);
        // R9 / R11: large mode with stalls and inputs changing while busy
        run_entry(1'b1, 7'd0, 16'h0F0F, 8'hFF, 16'h8001, 16'h0010, 1'b1, 1'b1);
        // R3: small mode with stack wrap below zero, back to back
        run_entry(1'b0, 7'd0, 16'h5555, 8'h80, 16'h7FFF, 16'h0002, 1'b1, 1'b0);
        run_entry(1'b0, 7'h7F, 16'h0001, 8'h01, 16'h0000, 16'h0000, 1'b1, 1'b1);
        // mixed random entries
        for (int n = 0; n < 60; n++) begin
            run_entry(1'($urandom), 7'($urandom), 16'($urandom), 8'($urandom),
                      16'($urandom), 16'($urandom), 1'($urandom), 1'($urandom));
            if ((n % 3) == 0) tick(1'b0, 1'($urandom), 1'($urandom));
        end
        for (int i = 0; i < 4; i++) tick(1'b0, 1'b1, 1'b1);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule